// File: doc/BRIEF.md
# Half-Duplex Radio Access Controller

The controller shares one half-duplex radio between two clients: a receiver that collects incoming frames and a sender that pushes outgoing frames byte by byte. The radio has a single interrupt line that means "a received byte is waiting" while listening and "the transmit register can take another byte" while sending. The controller tells these two meanings apart from its own mode (listen or send) and from which client owns its single access lock.

Listening is the resting mode. The first interrupt that arrives with the lock free is taken as the start of an incoming frame. The receive side then claims the lock and delivers every further byte until an upper framing layer flags end of frame. A send request waits for the lock. Once it has the lock, the controller switches the radio transmitter on and feeds it one byte per interrupt until the sender marks a byte as the final one. Completed incoming frames are announced through a one-entry mailbox that the receiver acknowledges. A frame that completes while the mailbox is still occupied is lost, and a saturating counter records the loss.

Top module: `radio_hd_ctrl`

## Requirements
- R1: While reset is asserted and on its release, radio_tx_en_o, tx_grant_o, rx_valid_o, radio_tx_we_o, tx_done_o and pkt_ready_o are 0 and drop_cnt_o is 0; the controller starts in listen mode with the lock free.
- R2: The controller never receives and transmits at once: rx_valid_o is never 1 while radio_tx_en_o is 1, and an interrupt while transmitting delivers no received byte.
- R3: An irq_i pulse in listen mode with the lock free claims the lock for the receive side; one clock later rx_valid_o is 1 for one cycle with rx_data_o equal to the rx_byte_i sampled with the pulse.
- R4: While the receive side holds the lock, each irq_i pulse delivers one more byte in the same way, and a pending tx_req_i is not granted (radio_tx_en_o stays 0).
- R5: eof_i while the receive side holds the lock frees the lock at the next edge; pkt_ready_o rises one clock after that when the mailbox was empty.
- R6: A frame that completes while pkt_ready_o is 1 and not acknowledged in that cycle is discarded: pkt_ready_o stays 1 and drop_cnt_o increases by one, saturating at 255. An acknowledge in the same cycle as the frame completion counts as taken, so the new frame is kept with no drop.
- R7: tx_req_i with the lock free and no irq_i gives the lock to the sender; one clock later radio_tx_en_o and tx_grant_o are 1.
- R8: While transmitting, each irq_i pulse makes radio_tx_we_o 1 for one cycle one clock later, with radio_tx_data_o equal to the tx_byte_i sampled with the pulse.
- R9: An irq_i pulse while transmitting with tx_last_i = 1 writes that byte, and in the same following cycle tx_done_o pulses, radio_tx_en_o and tx_grant_o drop to 0, and the controller is back in listen mode with the lock free.
- R10: When irq_i and tx_req_i arrive in the same cycle with the lock free, the interrupt wins: rx_valid_o pulses and radio_tx_en_o stays 0.
- R11: eof_i while the lock is free or held by the sender is ignored: pkt_ready_o, drop_cnt_o and radio_tx_en_o are unchanged by it.
- R12: pkt_ack_i clears pkt_ready_o at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Radio interrupt pulse, shared by receive and transmit events |
| rx_byte_i | input | DW | Byte read from the radio receive FIFO |
| rx_valid_o | output | 1 | One-cycle strobe: received byte on rx_data_o |
| rx_data_o | output | DW | Received byte passed upward |
| eof_i | input | 1 | End of incoming frame from the framing layer |
| pkt_ready_o | output | 1 | Mailbox holds a completed frame |
| pkt_ack_i | input | 1 | Receiver takes the mailbox entry |
| drop_cnt_o | output | CW | Saturating count of discarded frames |
| tx_req_i | input | 1 | Sender requests the radio for a frame |
| tx_byte_i | input | DW | Next byte to transmit |
| tx_last_i | input | 1 | tx_byte_i is the final byte of the frame |
| tx_grant_o | output | 1 | Sender owns the lock |
| tx_done_o | output | 1 | One-cycle strobe: frame fully written |
| radio_tx_en_o | output | 1 | Transmitter and its FIFO enabled |
| radio_tx_we_o | output | 1 | One-cycle write strobe into the radio transmit register; also tells the sender its byte was taken |
| radio_tx_data_o | output | DW | Byte written to the radio |

## Verification
Two pairs of events can meet in one cycle. A send request can arrive together with an interrupt while the lock is free. The bench raises both on the same edge and judges that a received byte appears and the transmitter stays off, even while the request is held on through the rest of that frame. A mailbox acknowledge can also fall on the very cycle a new frame completes. The bench lines the acknowledge up with the internal completion edge, one clock after end of frame, and judges that the mailbox stays full while the drop count does not move.

// File: rtl/hd_radio_pkg.sv
package hd_radio_pkg;
    typedef enum logic [1:0] {
        LK_FREE = 2'd0,
        LK_RX   = 2'd1,
        LK_TX   = 2'd2
    } lock_e;

    typedef enum logic {
        MODE_LISTEN = 1'b0,
        MODE_SEND   = 1'b1
    } mode_e;
endpackage

// File: rtl/hd_lock_fsm.sv
module hd_lock_fsm
    import hd_radio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_i,
    input  logic [DW-1:0] rx_byte_i,
    input  logic          eof_i,
    input  logic          tx_req_i,
    input  logic [DW-1:0] tx_byte_i,
    input  logic          tx_last_i,
    output mode_e         mode_o,
    output lock_e         lock_o,
    output logic          rx_valid_o,
    output logic [DW-1:0] rx_data_o,
    output logic          tx_we_o,
    output logic [DW-1:0] tx_data_o,
    output logic          tx_done_o,
    output logic          frame_end_o
);
    typedef struct packed {
        mode_e         mode;
        lock_e         lock;
        logic          rx_valid;
        logic [DW-1:0] rx_data;
        logic          tx_we;
        logic [DW-1:0] tx_data;
        logic          tx_done;
        logic          frame_end;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.rx_valid  = 1'b0;
        st_d.tx_we     = 1'b0;
        st_d.tx_done   = 1'b0;
        st_d.frame_end = 1'b0;
        unique case (st_q.lock)
            LK_FREE: begin
                // interrupt decodes as receive; it outranks a waiting send
                if (irq_i) begin
                    st_d.lock     = LK_RX;
                    st_d.rx_valid = 1'b1;
                    st_d.rx_data  = rx_byte_i;
                end else if (tx_req_i) begin
                    st_d.lock = LK_TX;
                    st_d.mode = MODE_SEND;
                end
            end
            LK_RX: begin
                if (irq_i) begin
                    st_d.rx_valid = 1'b1;
                    st_d.rx_data  = rx_byte_i;
                end
                if (eof_i) begin
                    st_d.lock      = LK_FREE;
                    st_d.frame_end = 1'b1;
                end
            end
            LK_TX: begin
                // interrupt decodes as transmit register ready
                if (irq_i) begin
                    st_d.tx_we   = 1'b1;
                    st_d.tx_data = tx_byte_i;
                    if (tx_last_i) begin
                        st_d.lock    = LK_FREE;
                        st_d.mode    = MODE_LISTEN;
                        st_d.tx_done = 1'b1;
                    end
                end
            end
            default: begin
                st_d.lock = LK_FREE;
                st_d.mode = MODE_LISTEN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode      <= MODE_LISTEN;
            st_q.lock      <= LK_FREE;
            st_q.rx_valid  <= 1'b0;
            st_q.rx_data   <= '0;
            st_q.tx_we     <= 1'b0;
            st_q.tx_data   <= '0;
            st_q.tx_done   <= 1'b0;
            st_q.frame_end <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o      = st_q.mode;
    assign lock_o      = st_q.lock;
    assign rx_valid_o  = st_q.rx_valid;
    assign rx_data_o   = st_q.rx_data;
    assign tx_we_o     = st_q.tx_we;
    assign tx_data_o   = st_q.tx_data;
    assign tx_done_o   = st_q.tx_done;
    assign frame_end_o = st_q.frame_end;
endmodule

// File: rtl/hd_mailbox.sv
module hd_mailbox #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_end_i,
    input  logic          ack_i,
    output logic          ready_o,
    output logic [CW-1:0] drop_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        logic          ready;
        logic [CW-1:0] drop;
    } mbox_t;

    mbox_t mb_d, mb_q;

    always_comb begin
        mb_d       = mb_q;
        mb_d.ready = mb_q.ready & ~ack_i;
        if (frame_end_i) begin
            if (mb_d.ready) begin
                if (mb_q.drop != CNT_MAX) begin
                    mb_d.drop = mb_q.drop + 1'b1;
                end
            end else begin
                mb_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mb_q.ready <= 1'b0;
            mb_q.drop  <= '0;
        end else begin
            mb_q <= mb_d;
        end
    end

    assign ready_o = mb_q.ready;
    assign drop_o  = mb_q.drop;
endmodule

// File: rtl/radio_hd_ctrl.sv
module radio_hd_ctrl
    import hd_radio_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_i,
    input  logic [DW-1:0] rx_byte_i,
    output logic          rx_valid_o,
    output logic [DW-1:0] rx_data_o,
    input  logic          eof_i,
    output logic          pkt_ready_o,
    input  logic          pkt_ack_i,
    output logic [CW-1:0] drop_cnt_o,
    input  logic          tx_req_i,
    input  logic [DW-1:0] tx_byte_i,
    input  logic          tx_last_i,
    output logic          tx_grant_o,
    output logic          tx_done_o,
    output logic          radio_tx_en_o,
    output logic          radio_tx_we_o,
    output logic [DW-1:0] radio_tx_data_o
);
    mode_e mode;
    lock_e lock;
    logic  frame_end;

    hd_lock_fsm #(.DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq_i),
        .rx_byte_i   (rx_byte_i),
        .eof_i       (eof_i),
        .tx_req_i    (tx_req_i),
        .tx_byte_i   (tx_byte_i),
        .tx_last_i   (tx_last_i),
        .mode_o      (mode),
        .lock_o      (lock),
        .rx_valid_o  (rx_valid_o),
        .rx_data_o   (rx_data_o),
        .tx_we_o     (radio_tx_we_o),
        .tx_data_o   (radio_tx_data_o),
        .tx_done_o   (tx_done_o),
        .frame_end_o (frame_end)
    );

    hd_mailbox #(.CW(CW)) u_mbox (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_end_i (frame_end),
        .ack_i       (pkt_ack_i),
        .ready_o     (pkt_ready_o),
        .drop_o      (drop_cnt_o)
    );

    assign radio_tx_en_o = (mode == MODE_SEND);
    assign tx_grant_o    = (lock == LK_TX);
endmodule

// File: rtl/radio_hd_ctrl_chk.sv
module radio_hd_ctrl_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid_o,
    input logic          radio_tx_en_o,
    input logic          radio_tx_we_o,
    input logic          tx_done_o,
    input logic          pkt_ready_o,
    input logic          pkt_ack_i,
    input logic [CW-1:0] drop_cnt_o
);
    a_r2_no_rx_while_tx: assert property (@(posedge clk) disable iff (!rst_n)
        !(radio_tx_en_o && rx_valid_o));

    a_r8_write_only_in_send: assert property (@(posedge clk) disable iff (!rst_n)
        radio_tx_we_o |-> $past(radio_tx_en_o));

    a_r9_done_back_to_listen: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |-> (!radio_tx_en_o && radio_tx_we_o));

    a_r6_drop_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt_o != $past(drop_cnt_o)) |-> $past(pkt_ready_o));

    a_r6_drop_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(drop_cnt_o) == {CW{1'b1}}) |-> (drop_cnt_o == {CW{1'b1}}));

    a_r12_clear_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pkt_ready_o) |-> $past(pkt_ack_i));
endmodule

bind radio_hd_ctrl radio_hd_ctrl_chk #(.CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid_o    (rx_valid_o),
    .radio_tx_en_o (radio_tx_en_o),
    .radio_tx_we_o (radio_tx_we_o),
    .tx_done_o     (tx_done_o),
    .pkt_ready_o   (pkt_ready_o),
    .pkt_ack_i     (pkt_ack_i),
    .drop_cnt_o    (drop_cnt_o)
);

// File: tb/test_radio_hd_ctrl.sv
module test_radio_hd_ctrl;
    localparam int DW = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_i = 1'b0;
    logic [DW-1:0] rx_byte_i = '0;
    logic          rx_valid_o;
    logic [DW-1:0] rx_data_o;
    logic          eof_i = 1'b0;
    logic          pkt_ready_o;
    logic          pkt_ack_i = 1'b0;
    logic [CW-1:0] drop_cnt_o;
    logic          tx_req_i = 1'b0;
    logic [DW-1:0] tx_byte_i = '0;
    logic          tx_last_i = 1'b0;
    logic          tx_grant_o;
    logic          tx_done_o;
    logic          radio_tx_en_o;
    logic          radio_tx_we_o;
    logic [DW-1:0] radio_tx_data_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_drop = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    radio_hd_ctrl #(.DW(DW), .CW(CW)) i_radio_hd_ctrl (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic rx_byte(input logic [DW-1:0] b, input string req);
        irq_i = 1'b1; rx_byte_i = b;
        step();
        irq_i = 1'b0;
        chk({req, " rx_valid"}, int'(rx_valid_o), 1);
        chk({req, " rx_data"}, int'(rx_data_o), int'(b));
    endtask

    task automatic end_frame();
        eof_i = 1'b1;
        step();
        eof_i = 1'b0;
        step();
    endtask

    task automatic t_reset();
        step(); step();
        chk("R1 tx_en", int'(radio_tx_en_o), 0);
        chk("R1 pkt_ready", int'(pkt_ready_o), 0);
        chk("R1 drop", int'(drop_cnt_o), 0);
        chk("R1 strobes", int'({rx_valid_o, radio_tx_we_o, tx_done_o, tx_grant_o}), 0);
        rst_n = 1'b1;
        step();
        chk("R1 after release", int'({radio_tx_en_o, pkt_ready_o, rx_valid_o}), 0);
    endtask

    task automatic t_rx_frame();
        rx_byte(8'h3C, "R3");
        tx_req_i = 1'b1;
        rx_byte(8'h81, "R4");
        chk("R4 send held off", int'(radio_tx_en_o), 0);
        rx_byte(8'hE7, "R4");
        step();
        chk("R4 send still held", int'(radio_tx_en_o), 0);
        tx_req_i = 1'b0;
        eof_i = 1'b1;
        step();
        eof_i = 1'b0;
        chk("R5 ready not yet", int'(pkt_ready_o), 0);
        step();
        chk("R5 ready", int'(pkt_ready_o), 1);
    endtask

    task automatic t_drop();
        rx_byte(8'h11, "R3");
        end_frame();
        exp_drop++;
        chk("R6 still ready", int'(pkt_ready_o), 1);
        chk("R6 drop count", int'(drop_cnt_o), exp_drop);
    endtask

    task automatic t_ack_same_cycle();
        rx_byte(8'h22, "R3");
        eof_i = 1'b1;
        step();
        eof_i = 1'b0;
        pkt_ack_i = 1'b1;
        step();
        pkt_ack_i = 1'b0;
        chk("R6 ack same cycle keeps frame", int'(pkt_ready_o), 1);
        chk("R6 ack same cycle no drop", int'(drop_cnt_o), exp_drop);
        pkt_ack_i = 1'b1;
        step();
        pkt_ack_i = 1'b0;
        chk("R12 ack clears", int'(pkt_ready_o), 0);
    endtask

    task automatic t_tx_frame();
        tx_req_i = 1'b1;
        step();
        chk("R7 tx_en", int'(radio_tx_en_o), 1);
        chk("R7 grant", int'(tx_grant_o), 1);
        eof_i = 1'b1;
        step();
        eof_i = 1'b0;
        step();
        chk("R11 eof in send ignored", int'(pkt_ready_o), 0);
        chk("R11 still sending", int'(radio_tx_en_o), 1);
        irq_i = 1'b1; tx_byte_i = 8'hA5; rx_byte_i = 8'h5A;
        step();
        irq_i = 1'b0;
        chk("R8 write strobe", int'(radio_tx_we_o), 1);
        chk("R8 write data", int'(radio_tx_data_o), 8'hA5);
        chk("R2 no rx in send", int'(rx_valid_o), 0);
        irq_i = 1'b1; tx_byte_i = 8'h6B; tx_last_i = 1'b1;
        step();
        irq_i = 1'b0; tx_last_i = 1'b0; tx_req_i = 1'b0;
        chk("R8 last data", int'(radio_tx_data_o), 8'h6B);
        chk("R9 done", int'(tx_done_o), 1);
        chk("R9 tx_en off", int'(radio_tx_en_o), 0);
        chk("R9 grant off", int'(tx_grant_o), 0);
        step();
        chk("R9 done is a pulse", int'(tx_done_o), 0);
        rx_byte(8'h47, "R9 back to listen");
        end_frame();
        chk("R9 frame after send", int'(pkt_ready_o), 1);
        pkt_ack_i = 1'b1; step(); pkt_ack_i = 1'b0;
    endtask

    task automatic t_collide();
        tx_req_i = 1'b1;
        rx_byte(8'h99, "R10");
        chk("R10 irq wins", int'(radio_tx_en_o), 0);
        step();
        chk("R10 send waits", int'(radio_tx_en_o), 0);
        tx_req_i = 1'b0;
        end_frame();
        chk("R10 frame kept", int'(pkt_ready_o), 1);
        pkt_ack_i = 1'b1; step(); pkt_ack_i = 1'b0;
    endtask

    task automatic t_eof_idle();
        end_frame();
        step();
        chk("R11 eof idle ready", int'(pkt_ready_o), 0);
        chk("R11 eof idle drop", int'(drop_cnt_o), exp_drop);
        chk("R11 eof idle tx_en", int'(radio_tx_en_o), 0);
    endtask

    task automatic t_saturate();
        rx_byte(8'h01, "R3");
        end_frame();
        chk("R6 mailbox filled", int'(pkt_ready_o), 1);
        for (int i = 0; i < 260; i++) begin
            irq_i = 1'b1; rx_byte_i = 8'(i);
            step();
            irq_i = 1'b0;
            end_frame();
            if (exp_drop < 255) exp_drop++;
        end
        chk("R6 saturated", int'(drop_cnt_o), 255);
        chk("R6 expected count", int'(drop_cnt_o), exp_drop);
    endtask

    initial begin
        t_reset();
        t_rx_frame();
        t_drop();
        t_ack_same_cycle();
        t_tx_frame();
        t_collide();
        t_eof_idle();
        t_saturate();
        step();
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end
endmodule